// File: doc/BRIEF.md
# I2C Single-Byte Register Transaction Sequencer

This block runs a complete register access to one I2C peripheral whose 7-bit bus address is fixed by a parameter. A caller presents an operation (read or write), an 8-bit register index and, for a write, one data byte, then pulses `go`. The block produces the whole bus transaction on two open-drain lines and reports completion with a one-cycle `done` pulse and an `error` flag. When a read succeeds, the received byte appears on `rd_data`.

The block has three layers. A sequencer decides which byte-level step comes next. A byte engine turns each step into single-bit operations and collects the acknowledge. A bit engine splits every bit into four equal quarter periods of the system clock and drives SCL and SDA. A write sends the device address with the direction bit clear, then the register index, then the data byte, and ends with a stop. A read first loads the register index through a write-direction phase. It then issues a repeated start with no stop in between, sends the device address with the direction bit set, takes in one byte, answers it with a not-acknowledge and ends with a stop. If the peripheral refuses any byte, the block stops at once and flags the error.

The lines are driven as open-drain: an output of 1 releases the line and 0 pulls it low. An external pull-up and the peripheral together form the wired-AND level, which returns on `sda_in`. Clock stretching and multi-byte bursts are not supported.

Top module: `i2c_regxfer`

## Requirements
- R1: After reset and whenever `busy` is low, both `scl_release` and `sda_release` are 1; the reset values of `busy`, `done`, `error` and `rd_data` are all 0.
- R2: A write (`op_read`=0) produces on the bus exactly: START, byte `{DEV_ADDR,1'b0}` (0xD0 by default), the register index, the data byte, STOP. Each byte is sent MSB first and acknowledged low by the peripheral, and `done` then comes with `error`=0.
- R3: A read (`op_read`=1) produces exactly: START, 0xD0, register index, a repeated START with no STOP before it, `{DEV_ADDR,1'b1}` (0xD1), one byte driven by the peripheral, a master acknowledge bit of 1 (NACK), STOP. `rd_data` then holds the received byte.
- R4: If the peripheral leaves SDA high in the acknowledge slot of any byte it receives (device address, register index, write data or read address), no further byte is sent. The next bus event is STOP, and `done` comes with `error`=1.
- R5: SDA changes only while SCL is low, except at the START, repeated START and STOP events listed in R2 to R4. No other start or stop condition appears on the bus.
- R6: A `go` pulse while `busy` is high has no effect: the running transaction completes unchanged and no second transaction follows it.
- R7: `busy` is high in the cycle after `go` is taken and stays high until `done`. `done` is a single-cycle pulse, and `busy` is already low in the cycle where `done` is high.
- R8: `rd_data` changes only when a read completes without a NACK; writes and aborted reads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, applied on the clock edge |
| go | input | 1 | Start request, taken only while idle |
| op_read | input | 1 | 1 = register read, 0 = register write |
| reg_addr | input | 8 | Register index inside the peripheral |
| wr_data | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| error | output | 1 | Valid with `done`: the peripheral refused a byte |
| rd_data | output | 8 | Last byte read successfully |
| scl_release | output | 1 | SCL open-drain control, 1 = released |
| sda_release | output | 1 | SDA open-drain control, 1 = released |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The hardest case to reach from the ports is a refusal in the acknowledge slot that follows the repeated start. The write phase has to succeed first, and then the peripheral has to reject its own read address. The bench's peripheral model counts the bytes it has received since the last stop and refuses the one at a programmable position. Directed transactions place that position on every slot of both operations, and random transactions mix refusals with reads and writes over a small set of register indices, so that reads return earlier written values. A second `go` pulse is also injected partway through a transaction to show that it is ignored.

// File: rtl/i2c_regxfer_pkg.sv
package i2c_regxfer_pkg;

   localparam int BYTE_BITS = 8;

   // single-bit operations of the line driver
   typedef enum logic [1:0] {
      BIT_START,
      BIT_STOP,
      BIT_WR,
      BIT_RD
   } bit_cmd_e;

   // byte-level steps issued by the sequencer
   typedef enum logic [1:0] {
      BC_START,
      BC_STOP,
      BC_WRITE,
      BC_READ
   } byte_cmd_e;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_START,
      SQ_DEVW,
      SQ_PTR,
      SQ_DATA,
      SQ_RSTART,
      SQ_DEVR,
      SQ_RECV,
      SQ_STOP
   } seq_state_e;

   // Line levels {scl, sda} for a quarter phase of a bit operation.
   // SDA moves only in quarters where SCL is low, except for the
   // deliberate transitions that form start and stop conditions.
   function automatic logic [1:0] bit_lines(bit_cmd_e c, logic [1:0] ph,
                                            logic b, logic scl_now);
      logic [1:0] r;
      r = 2'b11;
      unique case (c)
         BIT_START: begin
            unique case (ph)
               2'd0:    r = {scl_now, 1'b1};
               2'd1:    r = 2'b11;
               2'd2:    r = 2'b10;
               default: r = 2'b00;
            endcase
         end
         BIT_STOP: begin
            unique case (ph)
               2'd0:    r = 2'b00;
               2'd1:    r = 2'b10;
               default: r = 2'b11;
            endcase
         end
         BIT_WR: begin
            unique case (ph)
               2'd0, 2'd3: r = {1'b0, b};
               default:    r = {1'b1, b};
            endcase
         end
         default: begin
            unique case (ph)
               2'd0, 2'd3: r = 2'b01;
               default:    r = 2'b11;
            endcase
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/i2c_regxfer_bit.sv
module i2c_regxfer_bit
   import i2c_regxfer_pkg::*;
#(
   parameter int QUARTER_CYCLES = 125,
   parameter int SYNC_STAGES    = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cmd_valid,
   input  bit_cmd_e cmd,
   input  logic     din,
   output logic     done,
   output logic     dout,
   output logic     scl_o,
   output logic     sda_o,
   input  logic     sda_in
);

   localparam int CW = (QUARTER_CYCLES > 2) ? $clog2(QUARTER_CYCLES) : 1;
   localparam logic [CW-1:0] QLAST = CW'(QUARTER_CYCLES - 1);

   logic          sda_s;
   logic          busy_q;
   logic [1:0]    ph_q;
   logic [CW-1:0] cnt_q;
   bit_cmd_e      cmd_q;
   logic          b_q;

   // input synchroniser depth chosen by parameter
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sda_s = sda_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= (chain_q << 1) | SYNC_STAGES'(sda_in);
         end
         assign sda_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ph_q   <= 2'd0;
         cnt_q  <= '0;
         cmd_q  <= BIT_STOP;
         b_q    <= 1'b1;
         done   <= 1'b0;
         dout   <= 1'b1;
         scl_o  <= 1'b1;
         sda_o  <= 1'b1;
      end else begin
         done <= 1'b0;
         if (!busy_q) begin
            if (cmd_valid) begin
               busy_q         <= 1'b1;
               ph_q           <= 2'd0;
               cnt_q          <= '0;
               cmd_q          <= cmd;
               b_q            <= din;
               {scl_o, sda_o} <= bit_lines(cmd, 2'd0, din, scl_o);
            end
         end else if (cnt_q == QLAST) begin
            cnt_q <= '0;
            if (ph_q == 2'd2 && cmd_q == BIT_RD) dout <= sda_s;
            if (ph_q == 2'd3) begin
               busy_q <= 1'b0;
               done   <= 1'b1;
            end else begin
               ph_q           <= ph_q + 2'd1;
               {scl_o, sda_o} <= bit_lines(cmd_q, ph_q + 2'd1, b_q, scl_o);
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R5: during data and acknowledge bits SDA holds while SCL stays high
   p_sda_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (cmd_q == BIT_WR || cmd_q == BIT_RD) && scl_o && $past(scl_o))
         |-> $stable(sda_o));

   // R5: a bit operation is never accepted while another one runs
   p_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> (busy_q || done));

endmodule

// File: rtl/i2c_regxfer_byte.sv
module i2c_regxfer_byte
   import i2c_regxfer_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  byte_cmd_e       cmd,
   input  logic [BYTE_BITS-1:0] tx_byte,
   input  logic            nack_out,
   output logic            done,
   output logic            ack_in,
   output logic [BYTE_BITS-1:0] rx_byte,
   output logic            bit_valid,
   output bit_cmd_e        bit_cmd,
   output logic            bit_din,
   input  logic            bit_done,
   input  logic            bit_dout
);

   localparam int BW = $clog2(BYTE_BITS);
   localparam logic [BW-1:0] LASTBIT = BW'(BYTE_BITS - 1);

   typedef enum logic [1:0] {BY_IDLE, BY_SHIFT, BY_ACK, BY_SINGLE} by_state_e;

   by_state_e              st_q;
   byte_cmd_e              op_q;
   logic [BYTE_BITS-1:0]   sr_q;
   logic [BW-1:0]          cnt_q;
   logic                   nack_q;

   assign rx_byte = sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= BY_IDLE;
         op_q      <= BC_START;
         sr_q      <= '0;
         cnt_q     <= '0;
         nack_q    <= 1'b1;
         done      <= 1'b0;
         ack_in    <= 1'b1;
         bit_valid <= 1'b0;
         bit_cmd   <= BIT_STOP;
         bit_din   <= 1'b1;
      end else begin
         bit_valid <= 1'b0;
         done      <= 1'b0;
         unique case (st_q)
            BY_IDLE: begin
               if (cmd_valid) begin
                  op_q      <= cmd;
                  nack_q    <= nack_out;
                  sr_q      <= tx_byte;
                  cnt_q     <= '0;
                  bit_valid <= 1'b1;
                  unique case (cmd)
                     BC_START: begin
                        bit_cmd <= BIT_START;
                        bit_din <= 1'b1;
                        st_q    <= BY_SINGLE;
                     end
                     BC_STOP: begin
                        bit_cmd <= BIT_STOP;
                        bit_din <= 1'b1;
                        st_q    <= BY_SINGLE;
                     end
                     BC_WRITE: begin
                        bit_cmd <= BIT_WR;
                        bit_din <= tx_byte[BYTE_BITS-1];
                        st_q    <= BY_SHIFT;
                     end
                     default: begin
                        bit_cmd <= BIT_RD;
                        bit_din <= 1'b1;
                        st_q    <= BY_SHIFT;
                     end
                  endcase
               end
            end
            BY_SHIFT: begin
               if (bit_done) begin
                  bit_valid <= 1'b1;
                  if (op_q == BC_WRITE) sr_q <= sr_q << 1;
                  else                  sr_q <= {sr_q[BYTE_BITS-2:0], bit_dout};
                  if (cnt_q == LASTBIT) begin
                     st_q    <= BY_ACK;
                     bit_cmd <= (op_q == BC_WRITE) ? BIT_RD : BIT_WR;
                     bit_din <= (op_q == BC_WRITE) ? 1'b1 : nack_q;
                  end else begin
                     cnt_q   <= cnt_q + 1'b1;
                     bit_cmd <= (op_q == BC_WRITE) ? BIT_WR : BIT_RD;
                     bit_din <= (op_q == BC_WRITE) ? sr_q[BYTE_BITS-2] : 1'b1;
                  end
               end
            end
            BY_ACK: begin
               if (bit_done) begin
                  done <= 1'b1;
                  st_q <= BY_IDLE;
                  if (op_q == BC_WRITE) ack_in <= bit_dout;
               end
            end
            default: begin
               if (bit_done) begin
                  done <= 1'b1;
                  st_q <= BY_IDLE;
               end
            end
         endcase
      end
   end

   // R2: a byte step reports completion only once per request
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: the bit layer is never handed a new operation while this layer idles
   p_bit_req_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BY_IDLE && !cmd_valid) |=> !bit_valid);

endmodule

// File: rtl/i2c_regxfer_ctrl.sv
module i2c_regxfer_ctrl
   import i2c_regxfer_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h68
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            op_read,
   input  logic [BYTE_BITS-1:0] reg_addr,
   input  logic [BYTE_BITS-1:0] wr_data,
   output logic            busy,
   output logic            done,
   output logic            error,
   output logic [BYTE_BITS-1:0] rd_data,
   output logic            byte_valid,
   output byte_cmd_e       byte_cmd,
   output logic [BYTE_BITS-1:0] byte_tx,
   output logic            byte_nack,
   input  logic            byte_done,
   input  logic            byte_ack,
   input  logic [BYTE_BITS-1:0] rx_byte
);

   seq_state_e           st_q, st_n;
   logic                 op_q, err_q, abort_n;
   logic [BYTE_BITS-1:0] reg_q, dat_q;

   function automatic byte_cmd_e cmd_of(seq_state_e s);
      unique case (s)
         SQ_START, SQ_RSTART: return BC_START;
         SQ_STOP:             return BC_STOP;
         SQ_RECV:             return BC_READ;
         default:             return BC_WRITE;
      endcase
   endfunction

   always_comb begin
      st_n    = st_q;
      abort_n = 1'b0;
      unique case (st_q)
         SQ_IDLE:   if (go) st_n = SQ_START;
         SQ_START:  if (byte_done) st_n = SQ_DEVW;
         SQ_DEVW, SQ_DEVR: if (byte_done) begin
            abort_n = byte_ack;
            st_n    = byte_ack ? SQ_STOP : ((st_q == SQ_DEVW) ? SQ_PTR : SQ_RECV);
         end
         SQ_PTR: if (byte_done) begin
            abort_n = byte_ack;
            if (byte_ack)  st_n = SQ_STOP;
            else if (op_q) st_n = SQ_RSTART;
            else           st_n = SQ_DATA;
         end
         SQ_DATA: if (byte_done) begin
            abort_n = byte_ack;
            st_n    = SQ_STOP;
         end
         SQ_RSTART: if (byte_done) st_n = SQ_DEVR;
         SQ_RECV:   if (byte_done) st_n = SQ_STOP;
         default:   if (byte_done) st_n = SQ_IDLE;
      endcase
   end

   assign busy = (st_q != SQ_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         op_q       <= 1'b0;
         reg_q      <= '0;
         dat_q      <= '0;
         err_q      <= 1'b0;
         done       <= 1'b0;
         error      <= 1'b0;
         rd_data    <= '0;
         byte_valid <= 1'b0;
         byte_cmd   <= BC_STOP;
         byte_tx    <= '1;
         byte_nack  <= 1'b1;
      end else begin
         st_q       <= st_n;
         byte_valid <= (st_n != st_q) && (st_n != SQ_IDLE);
         byte_cmd   <= cmd_of(st_n);
         byte_nack  <= 1'b1;
         unique case (st_n)
            SQ_DEVW: byte_tx <= {DEV_ADDR, 1'b0};
            SQ_DEVR: byte_tx <= {DEV_ADDR, 1'b1};
            SQ_PTR:  byte_tx <= reg_q;
            SQ_DATA: byte_tx <= dat_q;
            default: byte_tx <= '1;
         endcase
         if (st_q == SQ_IDLE && go) begin
            op_q  <= op_read;
            reg_q <= reg_addr;
            dat_q <= wr_data;
            err_q <= 1'b0;
         end else if (abort_n) begin
            err_q <= 1'b1;
         end
         if (st_q == SQ_RECV && byte_done) rd_data <= rx_byte;
         done  <= (st_q == SQ_STOP) && byte_done;
         error <= (st_q == SQ_STOP) && byte_done && err_q;
      end
   end

   // R4: a refused byte leads straight to the stop step
   p_nack_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && byte_ack &&
       (st_q == SQ_DEVW || st_q == SQ_PTR || st_q == SQ_DATA || st_q == SQ_DEVR))
         |=> (st_q == SQ_STOP));

   // R4: the error flag only ever accompanies completion
   p_err_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

   // R6: requests arriving mid-transaction leave the captured request alone
   p_go_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && go) |=> ($stable(op_q) && $stable(reg_q) && $stable(dat_q)));

   // R7: completion is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: a taken request raises busy on the next cycle
   p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && go) |=> busy);

   // R8: an aborted transaction never alters the read result
   p_rd_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SQ_STOP && err_q) |=> $stable(rd_data));

endmodule

// File: rtl/i2c_regxfer.sv
module i2c_regxfer
   import i2c_regxfer_pkg::*;
#(
   parameter int         QUARTER_CYCLES = 125,
   parameter int         SYNC_STAGES    = 2,
   parameter logic [6:0] DEV_ADDR       = 7'h68
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       op_read,
   input  logic [7:0] reg_addr,
   input  logic [7:0] wr_data,
   output logic       busy,
   output logic       done,
   output logic       error,
   output logic [7:0] rd_data,
   output logic       scl_release,
   output logic       sda_release,
   input  logic       sda_in
);

   // elaboration checks on the timing parameters
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("i2c_regxfer: SYNC_STAGES must lie in 0..4");
      end
      if (QUARTER_CYCLES < SYNC_STAGES + 2) begin : g_bad_quarter
         $error("i2c_regxfer: QUARTER_CYCLES too short for the SDA synchroniser");
      end
   endgenerate

   logic                 byte_valid, byte_nack, byte_done, byte_ack;
   byte_cmd_e            byte_cmd;
   logic [BYTE_BITS-1:0] byte_tx, rx_byte;
   logic                 bit_valid, bit_din, bit_done, bit_dout;
   bit_cmd_e             bit_cmd;

   i2c_regxfer_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .op_read    (op_read),
      .reg_addr   (reg_addr),
      .wr_data    (wr_data),
      .busy       (busy),
      .done       (done),
      .error      (error),
      .rd_data    (rd_data),
      .byte_valid (byte_valid),
      .byte_cmd   (byte_cmd),
      .byte_tx    (byte_tx),
      .byte_nack  (byte_nack),
      .byte_done  (byte_done),
      .byte_ack   (byte_ack),
      .rx_byte    (rx_byte)
   );

   i2c_regxfer_byte u_byte (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (byte_valid),
      .cmd       (byte_cmd),
      .tx_byte   (byte_tx),
      .nack_out  (byte_nack),
      .done      (byte_done),
      .ack_in    (byte_ack),
      .rx_byte   (rx_byte),
      .bit_valid (bit_valid),
      .bit_cmd   (bit_cmd),
      .bit_din   (bit_din),
      .bit_done  (bit_done),
      .bit_dout  (bit_dout)
   );

   i2c_regxfer_bit #(
      .QUARTER_CYCLES (QUARTER_CYCLES),
      .SYNC_STAGES    (SYNC_STAGES)
   ) u_bit (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (bit_valid),
      .cmd       (bit_cmd),
      .din       (bit_din),
      .done      (bit_done),
      .dout      (bit_dout),
      .scl_o     (scl_release),
      .sda_o     (sda_release),
      .sda_in    (sda_in)
   );

   // R1: with no transaction running both lines are released
   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (scl_release && sda_release));

endmodule

// File: tb/sim_i2c_regxfer.sv
module sim_i2c_regxfer;

   localparam int QC       = 4;
   localparam int TK_START = 32'h1000;
   localparam int TK_STOP  = 32'h2000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       go = 1'b0;
   logic       op_read = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] wr_data = 8'h00;
   logic       busy, done, error, scl_release, sda_release;
   logic [7:0] rd_data;
   logic       slv_low = 1'b0;

   wire scl_w = scl_release;
   wire sda_w = sda_release & ~slv_low;

   always #10 clk = ~clk;

   i2c_regxfer #(.QUARTER_CYCLES(QC), .SYNC_STAGES(2), .DEV_ADDR(7'h68)) u0 (
      .clk(clk), .rst_n(rst_n), .go(go), .op_read(op_read),
      .reg_addr(reg_addr), .wr_data(wr_data), .busy(busy), .done(done),
      .error(error), .rd_data(rd_data), .scl_release(scl_release),
      .sda_release(sda_release), .sda_in(sda_w)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // ---------------- peripheral model ----------------
   logic [7:0] mem [0:255];
   logic [7:0] shadow [0:255];
   int   evlog [0:31];
   int   evn = 0;
   logic p_scl = 1'b1, p_sda = 1'b1;
   bit   active = 0, is_addr = 0, rd_mode = 0, ptr_set = 0, tx_on = 0, last_nk = 0;
   int   bitcnt = 0, rx_count = 0, nack_at = 0;
   logic [7:0] sh = 8'h00, tx = 8'h00, ptr = 8'h00;

   task automatic push(input int t);
      if (evn < 32) evlog[evn] = t;
      evn++;
   endtask

   task automatic slv_start();
      push(TK_START);
      active = 1; bitcnt = 0; is_addr = 1; ptr_set = 0; tx_on = 0; slv_low = 1'b0;
   endtask

   task automatic slv_stop();
      push(TK_STOP);
      active = 0; tx_on = 0; rx_count = 0; slv_low = 1'b0;
   endtask

   task automatic slv_rise();
      if (active) begin
         if (bitcnt < 8) begin
            sh = {sh[6:0], sda_w};
            bitcnt++;
         end else if (bitcnt == 8) begin
            push(int'(sh) * 2 + int'(sda_w));
            bitcnt = 9;
         end
      end
   endtask

   task automatic slv_fall();
      bit nk;
      if (active) begin
         if (bitcnt == 8) begin
            if (tx_on) slv_low = 1'b0;
            else begin
               rx_count++;
               nk = (rx_count == nack_at);
               if (is_addr) begin
                  rd_mode = sh[0];
                  if (sh[7:1] != 7'h68) nk = 1;
               end else if (!nk) begin
                  if (!ptr_set) begin ptr = sh; ptr_set = 1; end
                  else mem[ptr] = sh;
               end
               last_nk = nk;
               slv_low = !nk;
            end
         end else if (bitcnt == 9) begin
            bitcnt = 0;
            if (tx_on) begin
               tx_on = 0; slv_low = 1'b0;
            end else if (is_addr && rd_mode && !last_nk) begin
               tx_on = 1; tx = mem[ptr]; slv_low = !tx[7];
            end else slv_low = 1'b0;
            is_addr = 0;
         end else if (bitcnt >= 1 && bitcnt <= 7 && tx_on) begin
            slv_low = !tx[7-bitcnt];
         end
      end
   endtask

   always @(scl_w or sda_w) begin
      if (scl_w !== p_scl) begin
         p_scl = scl_w; p_sda = sda_w;
         if (scl_w === 1'b1) slv_rise(); else slv_fall();
      end else if (sda_w !== p_sda) begin
         p_sda = sda_w;
         if (scl_w === 1'b1) begin
            if (sda_w === 1'b0) slv_start(); else slv_stop();
         end
      end
   end

   // ---------------- expected values ----------------
   int   exp_log [0:31];
   int   exp_n = 0;
   bit   exp_err = 0;
   logic [7:0] exp_rd = 8'h00;

   task automatic add_byte(input int b, input int slot, input int na, output bit nk);
      nk = (slot == na);
      exp_log[exp_n] = b * 2 + (nk ? 1 : 0);
      exp_n++;
   endtask

   task automatic build_exp(input bit op, input logic [7:0] r, input logic [7:0] d,
                            input int na);
      bit nk;
      exp_n = 0;
      exp_log[exp_n] = TK_START; exp_n++;
      add_byte(8'hD0, 1, na, nk);
      if (!nk) add_byte(int'(r), 2, na, nk);
      if (!nk) begin
         if (!op) begin
            add_byte(int'(d), 3, na, nk);
            if (!nk) shadow[r] = d;
         end else begin
            exp_log[exp_n] = TK_START; exp_n++;
            add_byte(8'hD1, 3, na, nk);
            if (!nk) begin
               exp_log[exp_n] = int'(shadow[r]) * 2 + 1; exp_n++;
               exp_rd = shadow[r];
            end
         end
      end
      exp_err = nk;
      exp_log[exp_n] = TK_STOP; exp_n++;
   endtask

   function automatic int count_marks(input bit use_exp);
      int c = 0;
      int n = use_exp ? exp_n : evn;
      for (int i = 0; i < n && i < 32; i++) begin
         int t = use_exp ? exp_log[i] : evlog[i];
         if (t == TK_START || t == TK_STOP) c++;
      end
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // ---------------- one transaction ----------------
   task automatic run_txn(input bit op, input logic [7:0] r, input logic [7:0] d,
                          input int na, input bit poke, input string tag);
      int cyc;
      int bad;
      evn = 0;
      nack_at = na;
      build_exp(op, r, d, na);
      @(negedge clk);
      op_read = op; reg_addr = r; wr_data = d; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      chk(busy === 1'b1, "R7 busy after go", int'(busy), 1);
      if (poke) begin
         repeat (60) @(negedge clk);
         op_read = ~op; reg_addr = ~r; wr_data = ~d; go = 1'b1;
         @(negedge clk);
         go = 1'b0;
      end
      cyc = 0;
      while (done !== 1'b1 && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      chk(done === 1'b1, "R7 done seen", int'(done), 1);
      chk(error === exp_err, "R4 error flag", int'(error), int'(exp_err));
      chk(busy === 1'b0, "R7 busy low with done", int'(busy), 0);
      @(negedge clk);
      chk(done === 1'b0, "R7 done single pulse", int'(done), 0);
      chk(scl_release === 1'b1 && sda_release === 1'b1, "R1 lines released",
          {scl_release, sda_release}, 3);
      chk(rd_data === exp_rd, "R8 rd_data", int'(rd_data), int'(exp_rd));
      if (poke) begin
         // R6: no second transaction may follow the ignored request
         repeat (200) @(negedge clk);
         chk(busy === 1'b0 && evn == exp_n, "R6 no extra transaction", evn, exp_n);
      end
      chk(evn == exp_n, {tag, " event count"}, evn, exp_n);
      bad = -1;
      for (int i = 0; i < exp_n && i < 32; i++)
         if (bad < 0 && evlog[i] != exp_log[i]) bad = i;
      chk(bad < 0, {tag, " bus sequence"}, (bad < 0) ? 0 : evlog[bad],
          (bad < 0) ? 0 : exp_log[bad]);
      chk(count_marks(0) == count_marks(1), "R5 start/stop events",
          count_marks(0), count_marks(1));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=0 expected=1");
      summary();
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 256; i++) begin
         mem[i]    = 8'((i * 37 + 11) & 255);
         shadow[i] = 8'((i * 37 + 11) & 255);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R1 reset status",
          {busy, done, error}, 0);
      chk(rd_data === 8'h00, "R1 reset rd_data", int'(rd_data), 0);
      chk(scl_release === 1'b1 && sda_release === 1'b1, "R1 reset lines",
          {scl_release, sda_release}, 3);

      // directed: plain write then read back
      run_txn(1'b0, 8'h05, 8'hA5, 0, 1'b0, "R2 write");
      run_txn(1'b1, 8'h05, 8'h00, 0, 1'b0, "R3 read");
      run_txn(1'b1, 8'h80, 8'h00, 0, 1'b0, "R3 read untouched");
      // directed: refusal on every slot
      run_txn(1'b0, 8'h06, 8'h3C, 1, 1'b0, "R4 write nack addr");
      run_txn(1'b0, 8'h06, 8'h3C, 2, 1'b0, "R4 write nack reg");
      run_txn(1'b0, 8'h06, 8'h3C, 3, 1'b0, "R4 write nack data");
      run_txn(1'b1, 8'h06, 8'h00, 1, 1'b0, "R4 read nack addr");
      run_txn(1'b1, 8'h06, 8'h00, 2, 1'b0, "R4 read nack reg");
      run_txn(1'b1, 8'h06, 8'h00, 3, 1'b0, "R4 read nack read-addr R8");
      // directed: request during a transaction
      run_txn(1'b0, 8'h07, 8'hFF, 0, 1'b1, "R6 write with go");
      run_txn(1'b1, 8'h07, 8'h00, 0, 1'b1, "R6 read with go");
      run_txn(1'b0, 8'h00, 8'h00, 0, 1'b0, "R2 write zeros");
      run_txn(1'b1, 8'h00, 8'h00, 0, 1'b0, "R3 read zeros");

      // random mix
      for (int k = 0; k < 40; k++) begin
         bit         op = 1'($urandom % 2);
         logic [7:0] r  = 8'($urandom % 8);
         logic [7:0] d  = 8'($urandom);
         int         na = (($urandom % 4) == 0) ? int'($urandom % 3) + 1 : 0;
         run_txn(op, r, d, na, 1'b0, op ? "R3 random read" : "R2 random write");
      end
      summary();
   end

endmodule